// File: doc/BRIEF.md
# Four-Level Gray-Scale Segment Modulator

This block drives a row of LCD segment outputs so that each pixel can show one of four gray levels. Every pixel carries a 2-bit gray code. The code picks one of four 4-bit palette entries. That entry decides how often the segment is on, in two ways. Its upper two bits set how many frames are lit in a repeating four-frame cycle (frame rate control). Its lower two bits set how many quarters of a line period are lit within each lit frame (pulse-width modulation). The liquid crystal responds to the average drive, so the viewer sees an intermediate shade.

The frame phase is offset by the pixel's column and by the line number. Neighbouring pixels at the same gray level therefore do not all blink in the same frame. Software rewrites the palette through a small write port. Each write goes into a staging copy, and the staging copy is moved into the active palette only on a frame boundary, so one frame never shows a mix of old and new settings.

The timing inputs are a frame-start pulse and a line-start pulse. The block counts clock cycles within a line to find the current quarter.

Top module: `gray_frc_pwm`

## Requirements
- R1: After reset, palette entries 0, 1, 2 and 3 hold 0, 5, 10 and 15 (binary 0000, 0101, 1010, 1111). The frame count, line count and cycle-in-line count are all zero.
- R2: Segment i uses bits [2i+1:2i] of `pix_codes` as its gray code, and that code selects palette entry 0 to 3.
- R3: A segment whose palette value is 0 is off in every cycle.
- R4: A segment whose palette value is 15 is on in every cycle.
- R5: Let the palette value have upper bits U = value[3:2]. Segment i is lit only in frames whose slot is at most U, where slot = (frame count + (i mod 4) + line count) mod 4.
- R6: Let the palette value have lower bits L = value[1:0]. In a lit frame, the segment is on only while quarter ≤ L, where quarter = tick / (LINE_TICKS/4). The tick counts cycles since the last line or frame start and stops at LINE_TICKS-1.
- R7: A palette write changes the active palette only at the next `frame_start`. A write that arrives in the same cycle as `frame_start` is used for the frame that this pulse begins.
- R8: `frame_start` advances the frame count (mod 4) and clears both the line count and the tick. `line_start` advances the line count and clears the tick.
- R9: When `frame_start` and `line_start` arrive in the same cycle, only the frame-start effect happens: the line count becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse that opens a new frame |
| line_start | input | 1 | One-cycle pulse that opens a new line |
| pix_codes | input | 2*NSEG | 2-bit gray code for each segment |
| pal_we | input | 1 | Palette write strobe |
| pal_sel | input | 2 | Palette entry to write |
| pal_wdata | input | 4 | Palette value to write |
| seg | output | NSEG | Modulated segment drive bits |

## Verification
Two events can land on the same clock edge: a palette write and the frame boundary that promotes the staging palette. A line start can also coincide with a frame start. The bench forces both collisions on purpose. It then checks the segment pattern in the following cycles against a cycle-level model that gives the same-cycle write precedence and gives the frame start priority over the line start. Random pulse and write traffic around these directed cases also produces such collisions by chance, and those are judged by the same model.

// File: rtl/gfp_pkg.sv
package gfp_pkg;
  typedef logic [3:0] pal_t;

  // Default shade for gray code g: the code repeated in both halves.
  function automatic pal_t reset_pal(input logic [1:0] g);
    return pal_t'({g, g});
  endfunction

  // Segment state for a palette value, frame slot and line quarter.
  function automatic logic lit(input pal_t p, input logic [1:0] slot,
                               input logic [1:0] q);
    return (p != 4'd0) && (slot <= p[3:2]) && (q <= p[1:0]);
  endfunction
endpackage

// File: rtl/gfp_timing.sv
module gfp_timing #(
  parameter int LINE_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       line_start,
  output logic [1:0] frame_ph,
  output logic [1:0] line_ph,
  output logic [1:0] quarter
);
  localparam int TW   = (LINE_TICKS > 2) ? $clog2(LINE_TICKS) : 1;
  localparam int QT   = LINE_TICKS / 4;
  localparam int LAST = LINE_TICKS - 1;

  logic [TW-1:0] tick;
  logic          tick_at_end;

  assign tick_at_end = (int'(tick) == LAST);
  assign quarter     = 2'(int'(tick) / QT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_ph <= 2'd0;
      line_ph  <= 2'd0;
      tick     <= '0;
    end else if (frame_start) begin
      frame_ph <= frame_ph + 2'd1;
      line_ph  <= 2'd0;
      tick     <= '0;
    end else if (line_start) begin
      line_ph <= line_ph + 2'd1;
      tick    <= '0;
    end else if (!tick_at_end) begin
      tick <= tick + 1'b1;
    end
  end

  // R8
  frame_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> frame_ph == 2'($past(frame_ph) + 2'd1));
  // R9
  frame_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (line_ph == 2'd0) && (quarter == 2'd0));
  // R8
  line_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_start) |=> line_ph == 2'($past(line_ph) + 2'd1));
  // R6
  tick_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !line_start && tick_at_end) |=> tick_at_end);
endmodule

// File: rtl/gfp_palette.sv
module gfp_palette
  import gfp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            pal_we,
  input  logic [1:0]      pal_sel,
  input  logic [3:0]      pal_wdata,
  output logic [3:0][3:0] active
);
  logic [3:0][3:0] staged;

  for (genvar g = 0; g < 4; g++) begin : g_entry
    logic hit;
    assign hit = pal_we && (pal_sel == 2'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        staged[g] <= reset_pal(2'(g));
        active[g] <= reset_pal(2'(g));
      end else begin
        if (hit) staged[g] <= pal_wdata;
        if (frame_start) active[g] <= hit ? pal_wdata : staged[g];
      end
    end
  end

  // R7
  pal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(active));
  // R7
  pal_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && pal_we) |=> active[$past(pal_sel)] == $past(pal_wdata));
endmodule

// File: rtl/gfp_lane.sv
module gfp_lane
  import gfp_pkg::*;
#(
  parameter int COL = 0
) (
  input  logic [3:0] pal,
  input  logic [1:0] frame_ph,
  input  logic [1:0] line_ph,
  input  logic [1:0] quarter,
  output logic       seg_o
);
  localparam logic [1:0] COL_OFS = 2'(COL % 4);

  logic [1:0] slot;
  assign slot  = frame_ph + line_ph + COL_OFS;
  assign seg_o = lit(pal, slot, quarter);
endmodule

// File: rtl/gray_frc_pwm.sv
module gray_frc_pwm
  import gfp_pkg::*;
#(
  parameter int NSEG       = 8,
  parameter int LINE_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic [2*NSEG-1:0] pix_codes,
  input  logic              pal_we,
  input  logic [1:0]        pal_sel,
  input  logic [3:0]        pal_wdata,
  output logic [NSEG-1:0]   seg
);
  logic [3:0][3:0] active;
  logic [1:0]      frame_ph, line_ph, quarter;

  gfp_timing #(.LINE_TICKS(LINE_TICKS)) u_timing (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .line_start(line_start), .frame_ph(frame_ph), .line_ph(line_ph),
    .quarter(quarter)
  );

  gfp_palette u_palette (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .pal_we(pal_we), .pal_sel(pal_sel), .pal_wdata(pal_wdata),
    .active(active)
  );

  for (genvar i = 0; i < NSEG; i++) begin : g_lane
    logic [1:0] code;
    logic [3:0] lane_pal;
    assign code     = pix_codes[2*i +: 2];
    assign lane_pal = active[code];

    gfp_lane #(.COL(i)) u_lane (
      .pal(lane_pal), .frame_ph(frame_ph), .line_ph(line_ph),
      .quarter(quarter), .seg_o(seg[i])
    );

    // R3
    dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_pal == 4'd0) |-> !seg[i]);
    // R4
    full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_pal == 4'd15) |-> seg[i]);
  end
endmodule

// File: tb/gray_frc_pwm_tb.sv
module gray_frc_pwm_tb;
  localparam int NSEG = 8;
  localparam int LT   = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frame_start = 1'b0, line_start = 1'b0, pal_we = 1'b0;
  logic [1:0]        pal_sel = '0;
  logic [3:0]        pal_wdata = '0;
  logic [2*NSEG-1:0] pix_codes = '0;
  logic [NSEG-1:0]   seg;

  int checks = 0, failures = 0;
  logic [3:0] m_sh[4], m_act[4];
  int m_fr, m_ln, m_tk;

  always #2.5 clk = ~clk;

  gray_frc_pwm #(.NSEG(NSEG), .LINE_TICKS(LT)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .line_start(line_start), .pix_codes(pix_codes), .pal_we(pal_we),
    .pal_sel(pal_sel), .pal_wdata(pal_wdata), .seg(seg)
  );

  function automatic logic [NSEG-1:0] expect_seg();
    logic [NSEG-1:0] r = '0;
    for (int i = 0; i < NSEG; i++) begin
      int code = int'(pix_codes[2*i +: 2]);
      int p = int'(m_act[code]);
      int slot = (m_fr + (i % 4) + m_ln) % 4;
      int q = m_tk / (LT / 4);
      int frames_on = p / 4 + 1;
      int quarters_on = p % 4 + 1;
      r[i] = (p != 0) && (slot < frames_on) && (q < quarters_on);
    end
    return r;
  endfunction

  task automatic model_reset();
    for (int g = 0; g < 4; g++) begin
      m_sh[g] = 4'(g * 5);
      m_act[g] = 4'(g * 5);
    end
    m_fr = 0; m_ln = 0; m_tk = 0;
  endtask

  task automatic step(input logic fs, input logic ls, input logic we,
                      input logic [1:0] sel, input logic [3:0] wd,
                      input logic [2*NSEG-1:0] px, input string tag);
    logic [NSEG-1:0] exp_v;
    @(negedge clk);
    frame_start = fs; line_start = ls; pal_we = we;
    pal_sel = sel; pal_wdata = wd; pix_codes = px;
    @(posedge clk);
    if (fs) begin
      for (int g = 0; g < 4; g++)
        m_act[g] = (we && sel == 2'(g)) ? wd : m_sh[g];
      m_fr = (m_fr + 1) % 4; m_ln = 0; m_tk = 0;
    end else if (ls) begin
      m_ln = (m_ln + 1) % 4; m_tk = 0;
    end else if (m_tk < LT - 1) begin
      m_tk++;
    end
    if (we) m_sh[sel] = wd;
    #1;
    exp_v = expect_seg();
    checks++;
    if (seg !== exp_v) begin
      failures++;
      $display("FAIL %s: seg=%b expected=%b", tag, seg, exp_v);
    end
  endtask

  function automatic logic [2*NSEG-1:0] fill(input logic [1:0] c);
    return {NSEG{c}};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (seg !== expect_seg()) begin
      failures++;
      $display("FAIL R1: seg=%b expected=%b", seg, expect_seg());
    end
    // R1: default palette seen over a full frame cycle per code
    for (int c = 0; c < 4; c++)
      for (int f = 0; f < 4; f++) begin
        step(1, 0, 0, 0, 0, fill(2'(c)), "R1");
        for (int t = 0; t < LT; t++) step(0, 0, 0, 0, 0, fill(2'(c)), "R1");
      end
    // R3 / R4: extreme palettes under line traffic
    step(0, 0, 1, 2'd1, 4'd0, fill(2'd1), "R3");
    step(0, 0, 1, 2'd2, 4'd15, fill(2'd2), "R4");
    step(1, 0, 0, 0, 0, fill(2'd1), "R3");
    for (int t = 0; t < 20; t++)
      step(0, (t % 5) == 4, 0, 0, 0, fill(2'd1), "R3");
    for (int t = 0; t < 20; t++)
      step((t % 9) == 8, (t % 5) == 4, 0, 0, 0, fill(2'd2), "R4");
    // R2: distinct palettes, mixed codes per lane
    step(0, 0, 1, 2'd0, 4'd6, fill(2'd0), "R2");
    step(0, 0, 1, 2'd1, 4'd9, fill(2'd0), "R2");
    step(0, 0, 1, 2'd2, 4'd3, fill(2'd0), "R2");
    step(0, 0, 1, 2'd3, 4'd13, fill(2'd0), "R2");
    step(1, 0, 0, 0, 0, 16'hE4B1, "R2");
    for (int t = 0; t < 24; t++)
      step(0, (t % 8) == 7, 0, 0, 0, 16'hE4B1 ^ 16'(t * 37), "R2");
    // R6: long line, tick saturates at last quarter
    step(0, 1, 0, 0, 0, fill(2'd3), "R6");
    for (int t = 0; t < 3 * LT; t++) step(0, 0, 0, 0, 0, 16'h1B1B, "R6");
    // R7: write without frame_start must not change output
    step(0, 0, 1, 2'd3, 4'd0, fill(2'd3), "R7");
    for (int t = 0; t < 6; t++) step(0, 0, 0, 0, 0, fill(2'd3), "R7");
    step(1, 0, 0, 0, 0, fill(2'd3), "R7");
    // R7: write colliding with frame_start is used at once
    step(1, 0, 1, 2'd3, 4'd15, fill(2'd3), "R7");
    step(0, 0, 0, 0, 0, fill(2'd3), "R7");
    step(1, 0, 1, 2'd0, 4'd2, fill(2'd0), "R7");
    for (int t = 0; t < 4; t++) step(0, 0, 0, 0, 0, fill(2'd0), "R7");
    // R9: frame and line start together
    step(0, 1, 0, 0, 0, 16'h6C93, "R9");
    step(1, 1, 0, 0, 0, 16'h6C93, "R9");
    for (int t = 0; t < 4; t++) step(0, 0, 0, 0, 0, 16'h6C93, "R9");
    // R8: line sequence walks slots
    for (int t = 0; t < 16; t++) step(0, 1, 0, 0, 0, 16'h55AA, "R8");
    // R5: random traffic
    for (int t = 0; t < 3000; t++) begin
      logic fs = ($urandom % 40) == 0;
      logic ls = ($urandom % 6) == 0;
      logic we = ($urandom % 25) == 0;
      step(fs, ls, we, 2'($urandom), 4'($urandom),
           2*NSEG'($urandom), "R5");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule